// File: doc/BRIEF.md
# Reference Clock Loss Monitor

This block runs from the local free-running crystal clock. It decides whether a nominal 8 kHz reference input is present. The reference is first brought into the local clock domain through a synchronizer. Its rising edges are then counted inside back-to-back observation windows, each lasting three reference periods. At every window boundary the block updates a presence flag and a source-select output. The source-select steers the downstream loop either to the reference-locked path or to the free-running crystal.

The same block gates the clock-output enable. After reset the enable stays low for a settling interval. The shutdown input is active low. Pulling it low drops the enable at once and raises a power-down request to both loops. When shutdown is released, the power-down request clears and a fresh settling interval starts before the outputs are enabled again.

Two state machines do the work. The window machine has states `REF_LOST` and `REF_PRESENT`. It moves from `REF_LOST` to `REF_PRESENT` through the transition T_ACQUIRE, taken at a boundary with enough edges. It moves back through T_DROP, taken at a boundary with too few edges. The enable machine has states `HOLD_OFF`, `HOLD_WAIT` and `HOLD_RUN`:
- T_SHUTDOWN: any state goes to `HOLD_OFF` while shutdown is low.
- T_RELEASE: `HOLD_OFF` goes to `HOLD_WAIT` once shutdown is high.
- T_SETTLED: `HOLD_WAIT` goes to `HOLD_RUN` when the hold count completes.

Top module: `refclk_monitor`

## Requirements
- R1: Only low-to-high transitions of the reference are counted. An edge is counted two local clock edges after the reference is first sampled high, following a sample that was low. A steady high level contributes no edges.
- R2: Windows are WIN_CYCLES local cycles long. They repeat without gaps, and the first one starts at reset release. Boundaries fall on local edges WIN_CYCLES, 2×WIN_CYCLES and so on after release.
- R3: A window with fewer than two counted rising edges sets `ref_valid` to 0 at its boundary.
- R4: A window with two or more counted rising edges sets `ref_valid` to 1 at its boundary. The edge counter saturates, so a fast or glitchy reference still reads as present.
- R5: `ref_valid` changes only at window boundaries. `sel_ref` always equals `ref_valid`: 1 selects the reference-locked loop and 0 selects the free-running crystal.
- R6: During and right after reset, with shutdown high, the outputs read as follows: `ref_valid`=0, `sel_ref`=0, `out_en`=0 and `pwr_dn`=0.
- R7: With shutdown held high from reset, `out_en` rises after exactly HOLD_CYCLES local edges following reset release.
- R8: While `shdn_n` is low, `out_en` is 0 and `pwr_dn` is 1 within the same cycle, without waiting for a clock edge.
- R9: After `shdn_n` returns high, `pwr_dn` falls at the next local edge. `out_en` rises HOLD_CYCLES+1 edges after that release. Any new shutdown restarts this count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous 8 kHz reference input |
| shdn_n | input | 1 | Active-low shutdown request, synchronous to clk |
| ref_valid | output | 1 | Reference judged present in the last window |
| sel_ref | output | 1 | 1 = reference-locked loop, 0 = crystal |
| out_en | output | 1 | Clock output enable |
| pwr_dn | output | 1 | Power-down request to both loops |

## Verification
A corrupted window count or edge count shows up at the next boundary as a wrong `ref_valid`. That boundary is at most WIN_CYCLES cycles away, so such a fault is visible within one window. A wrong synchronizer depth shifts the boundary at which a sparse edge pattern is counted. A fault in the enable machine shows as an `out_en` edge one or more cycles off the expected HOLD_CYCLES mark, or as `pwr_dn` lingering past the first edge after release. Comparing all four outputs on every clock exposes each of these faults in the cycle it first appears.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic {
        REF_LOST,
        REF_PRESENT
    } ref_state_t;

    typedef enum logic [1:0] {
        HOLD_OFF,
        HOLD_WAIT,
        HOLD_RUN
    } hold_state_t;

    localparam int MIN_EDGES = 2;
endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], ref_in};
    end

    always_comb rise = chain[STAGES-1] & ~chain[STAGES];

    // R1: a counted edge implies the reference was high STAGES edges earlier
    p_rise_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(ref_in, STAGES));
endmodule

// File: rtl/refmon_window.sv
module refmon_window
    import refmon_pkg::*;
#(
    parameter int WIN_CYCLES = 6624
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic ref_valid
);
    localparam int WW = $clog2(WIN_CYCLES);
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    ref_state_t state, state_nx;
    logic [WW-1:0] wcnt;
    logic [1:0]    ecnt;
    logic [2:0]    ecnt_sum;
    logic          boundary;
    logic          enough;

    always_comb begin
        boundary = (wcnt == LAST);
        ecnt_sum = {1'b0, ecnt} + {2'b00, rise};
        enough   = (ecnt_sum >= 3'(MIN_EDGES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            ecnt <= '0;
        end else if (boundary) begin
            wcnt <= '0;
            ecnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
            if (rise && ecnt != 2'd3) ecnt <= ecnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            REF_LOST:    if (boundary && enough)  state_nx = REF_PRESENT; // T_ACQUIRE
            REF_PRESENT: if (boundary && !enough) state_nx = REF_LOST;    // T_DROP
            default:     state_nx = REF_LOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REF_LOST;
        else        state <= state_nx;
    end

    always_comb ref_valid = (state == REF_PRESENT);

    // R5: the flag moves only on a window boundary
    p_valid_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_valid) |-> $past(boundary));

    // R3: an empty window ends in the lost state
    p_empty_window_lost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ecnt == 2'd0 && !rise) |=> !ref_valid);
endmodule

// File: rtl/refmon_hold.sv
module refmon_hold
    import refmon_pkg::*;
#(
    parameter int HOLD_CYCLES = 4521984
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    output logic out_en,
    output logic pwr_dn
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

    hold_state_t state, state_nx;
    logic [HW-1:0] cnt;

    always_comb begin
        state_nx = state;
        if (!shdn_n) begin
            state_nx = HOLD_OFF;                                 // T_SHUTDOWN
        end else begin
            unique case (state)
                HOLD_OFF:  state_nx = HOLD_WAIT;                 // T_RELEASE
                HOLD_WAIT: if (cnt == LAST) state_nx = HOLD_RUN; // T_SETTLED
                HOLD_RUN:  state_nx = HOLD_RUN;
                default:   state_nx = HOLD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HOLD_WAIT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == HOLD_WAIT && shdn_n) cnt <= cnt + 1'b1;
            else                              cnt <= '0;
        end
    end

    always_comb begin
        out_en = (state == HOLD_RUN) && shdn_n;
        pwr_dn = (state == HOLD_OFF) || !shdn_n;
    end

    // R9: enabled outputs imply shutdown was high at the previous edge
    p_run_needs_shdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> $past(shdn_n));

    // R7: the enable rises only when the settling count completes
    p_rise_after_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> ($past(state) == HOLD_WAIT && $past(cnt) == LAST));

    // R8: a sampled shutdown keeps the loops powered down next cycle
    p_shdn_powers_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> pwr_dn);
endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor #(
    parameter int WIN_CYCLES  = 6624,
    parameter int HOLD_CYCLES = 4521984,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic shdn_n,
    output logic ref_valid,
    output logic sel_ref,
    output logic out_en,
    output logic pwr_dn
);
    logic rise;

    refmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rise   (rise)
    );

    refmon_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .ref_valid (ref_valid)
    );

    refmon_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .shdn_n (shdn_n),
        .out_en (out_en),
        .pwr_dn (pwr_dn)
    );

    always_comb sel_ref = ref_valid;
endmodule

// File: tb/sim_refclk_monitor.sv
`timescale 1ns/1ps
module sim_refclk_monitor;
    localparam int W = 30;
    localparam int H = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic shdn_n = 1'b1;
    logic ref_valid, sel_ref, out_en, pwr_dn;

    int n_chk = 0;
    int n_fail = 0;
    int period_cfg = 0;
    logic level_cfg = 1'b0;
    int phase = 0;
    bit done = 0;

    // behavioural model state
    int h1 = 0, h2 = 0, h3 = 0;
    int nedge = 0, wpos = 0, since = 0;
    logic valid_m = 1'b0;

    always #5 clk = ~clk;

    refclk_monitor #(.WIN_CYCLES(W), .HOLD_CYCLES(H), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .shdn_n(shdn_n),
        .ref_valid(ref_valid), .sel_ref(sel_ref), .out_en(out_en), .pwr_dn(pwr_dn)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // reference waveform driver
    always @(negedge clk) begin
        if (period_cfg == 0) begin
            ref_in = level_cfg;
        end else begin
            phase = (phase + 1) % period_cfg;
            ref_in = (phase < period_cfg / 2);
        end
    end

    // cycle-by-cycle reference model and comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; nedge = 0; wpos = 0; since = 0;
            valid_m = 1'b0;
        end else begin
            if (h2 == 1 && h3 == 0) nedge++;  // R1 two-edge synchronizer latency
            h3 = h2; h2 = h1; h1 = int'(ref_in);
            wpos++;
            if (wpos == W) begin               // R2 boundary
                valid_m = (nedge >= 2);
                nedge = 0;
                wpos = 0;
            end
            if (!shdn_n) since = -1;
            else if (since < H + 10) since++;
        end
        #3;
        if (!done) begin
            chk(valid_m ? "R4" : "R3", ref_valid, valid_m);
            chk("R5", sel_ref, valid_m);
            chk("R7", out_en, (since >= H) && shdn_n);
            chk("R9", pwr_dn, !shdn_n || since < 0);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(4);
        #1;
        chk("R6", ref_valid, 1'b0);
        chk("R6", sel_ref, 1'b0);
        chk("R6", out_en, 1'b0);
        chk("R6", pwr_dn, 1'b0);
        rst_n = 1'b1;
        wait_cyc(H - 2);
        chk("R7", out_en, 1'b0);
        wait_cyc(12);
        chk("R7", out_en, 1'b1);
        chk("R3", ref_valid, 1'b0);

        period_cfg = 10; wait_cyc(120);
        chk("R4", ref_valid, 1'b1);
        period_cfg = 15; wait_cyc(150);
        chk("R4", ref_valid, 1'b1);
        period_cfg = 2; wait_cyc(90);
        chk("R4", ref_valid, 1'b1);
        period_cfg = 0; level_cfg = 1'b1; wait_cyc(120);
        chk("R1", ref_valid, 1'b0);
        chk("R5", sel_ref, 1'b0);
        level_cfg = 1'b0; period_cfg = 10; wait_cyc(90);
        chk("R4", ref_valid, 1'b1);

        shdn_n = 1'b0; #1;
        chk("R8", out_en, 1'b0);
        chk("R8", pwr_dn, 1'b1);
        wait_cyc(20);
        shdn_n = 1'b1;
        wait_cyc(H + 5);
        chk("R9", out_en, 1'b1);
        chk("R9", pwr_dn, 1'b0);

        shdn_n = 1'b0; wait_cyc(3);
        shdn_n = 1'b1; wait_cyc(20);
        shdn_n = 1'b0; wait_cyc(3);
        shdn_n = 1'b1; wait_cyc(H - 5);
        chk("R9", out_en, 1'b0);
        wait_cyc(10);
        chk("R9", out_en, 1'b1);

        period_cfg = 40; wait_cyc(200);
        chk("R3", ref_valid, 1'b0);
        period_cfg = 0; level_cfg = 1'b0; wait_cyc(90);
        chk("R3", ref_valid, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule